// File: doc/BRIEF.md
# Multi-Stage Sample Trigger Sequencer

This block watches a 32-channel sample stream and decides when a logic-analyzer capture should start. It holds four trigger stages. Each stage has four 32-bit words: a mask, a value, an edge-select word and a config word. The host writes them one word at a time through a register port. A small level counter records which stage is currently being looked for. On every sample-valid cycle, only the stages whose config level equals the counter take part.

A channel bit that is masked and not edge-selected must equal the value bit. A channel bit that is masked and edge-selected must show a transition between the previous and current sample. A value bit of one asks for a rising edge, and zero asks for a falling edge. When a participating stage matches and its start flag is set, the block raises a one-cycle fire pulse and then stays quiet until it is re-armed. When a participating stage matches without the start flag, the counter moves to the next level.

A stage that should take no part is parked with a config level of 3 and zero mask, value and edge words. A stage with an all-zero mask matches on the first valid sample, which lets the host start a capture at once when it has no trigger to set.

Top module: `trig_seq`

## Requirements
- R1: After reset, `fire` and `fired` are 0 and `level` is 0. Every stage's config word resets to 0x0003_0000 (level 3, no start flag), and its mask, value and edge words reset to 0. As a result, no sample fires the trigger.
- R2: A write with `cfg_we` high stores `cfg_data` into one register. `cfg_addr[3:2]` selects the stage. `cfg_addr[1:0]` selects the word: 0 is the mask, 1 the value, 2 the config and 3 the edge-select. No other register changes.
- R3: For channels that are masked and not edge-selected, a stage matches only when the current sample equals the value bit on each such channel.
- R4: For channels that are masked and edge-selected, value bit 1 requires previous=0 and current=1. Value bit 0 requires previous=1 and current=0. No change, or a change in the wrong direction, is no match.
- R5: Only stages whose config bits [23:16] equal the level counter are evaluated. Stages at other levels have no effect.
- R6: If an evaluated stage matches on a valid sample and has config bit 27 (the start flag) set, `fire` is 1 in the cycle after that sample and `fired` becomes 1.
- R7: If an evaluated stage matches without the start flag, `level` rises by one in the next cycle. The counter saturates at 3.
- R8: `fire` lasts one cycle. While `fired` is 1, further matches neither fire again nor move `level`.
- R9: When `arm` is high, `level`, `fired` and `fire` are cleared in the next cycle, and no sample is evaluated in that cycle.
- R10: While `smp_valid` is 0, `level`, `fire` and `fired` do not change due to the sample inputs.
- R11: A stage with an all-zero mask matches on any valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Start a new capture: clear level and fired state |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | [3:2] stage, [1:0] word kind |
| cfg_data | input | 32 | Register write data |
| smp_valid | input | 1 | Sample strobe |
| smp_cur | input | 32 | Current sample |
| smp_prev | input | 32 | Previous sample |
| fire | output | 1 | One-cycle capture-start pulse |
| fired | output | 1 | Trigger has fired since last arm |
| level | output | 2 | Current stage level |

## Verification
A wrong level counter shows at the `level` port in the cycle after the sample that moved it. It also shows as a fire pulse that is missing or arrives at the wrong time on a later sample. A matcher that ignores a masked channel, or accepts the wrong edge direction, produces a `fire` one cycle after the offending sample. The bench sweeps every channel in both polarities, and in both edge directions, so such a fault is exposed in the first sweep step that touches that channel. A sticky state that fails to clear shows up right after the next `arm`, when `fired` stays high or `level` is not zero.

// File: rtl/trg_pkg.sv
package trg_pkg;
    localparam int CH_W       = 32;
    localparam int N_STAGES   = 4;
    localparam int LVL_W      = $clog2(N_STAGES);
    localparam int ADDR_W     = LVL_W + 2;
    localparam int LEVEL_LSB  = 16;
    localparam int START_BIT  = 27;
    localparam logic [CH_W-1:0] CFG_PARKED = 32'h0003_0000;

    typedef enum logic [1:0] {
        WORD_MASK  = 2'd0,
        WORD_VALUE = 2'd1,
        WORD_CFG   = 2'd2,
        WORD_EDGE  = 2'd3
    } word_kind_e;

    typedef struct packed {
        logic [CH_W-1:0] mask;
        logic [CH_W-1:0] value;
        logic [CH_W-1:0] cfg;
        logic [CH_W-1:0] edge_sel;
    } stage_cfg_t;

    function automatic logic [7:0] cfg_level(input logic [CH_W-1:0] c);
        return c[LEVEL_LSB +: 8];
    endfunction

    function automatic logic cfg_start(input logic [CH_W-1:0] c);
        return c[START_BIT];
    endfunction
endpackage

// File: rtl/trg_stage_regs.sv
module trg_stage_regs
    import trg_pkg::*;
#(
    parameter int NST = N_STAGES,
    parameter int AW  = ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [AW-1:0]         addr,
    input  logic [CH_W-1:0]       wdata,
    output stage_cfg_t [NST-1:0]  stages
);
    localparam int SW = AW - 2;

    for (genvar s = 0; s < NST; s++) begin : g_stage
        logic hit;
        assign hit = we && (addr[AW-1:2] == SW'(s));
        always_ff @(posedge clk) begin
            if (rst) begin
                stages[s].mask     <= '0;
                stages[s].value    <= '0;
                stages[s].cfg      <= CFG_PARKED;
                stages[s].edge_sel <= '0;
            end else if (hit) begin
                case (word_kind_e'(addr[1:0]))
                    WORD_MASK:  stages[s].mask     <= wdata;
                    WORD_VALUE: stages[s].value    <= wdata;
                    WORD_CFG:   stages[s].cfg      <= wdata;
                    WORD_EDGE:  stages[s].edge_sel <= wdata;
                    default:    ;
                endcase
            end
        end
    end
endmodule

// File: rtl/trg_stage_match.sv
module trg_stage_match
    import trg_pkg::*;
#(
    parameter int LW = LVL_W
) (
    input  stage_cfg_t       cfg,
    input  logic [CH_W-1:0]  cur,
    input  logic [CH_W-1:0]  prev,
    input  logic [LW-1:0]    level,
    output logic             sel,
    output logic             hit,
    output logic             start
);
    logic [CH_W-1:0] lvl_miss;
    logic [CH_W-1:0] rise, fall, want;
    logic [CH_W-1:0] edge_miss;

    always_comb begin
        lvl_miss  = (cur ^ cfg.value) & cfg.mask & ~cfg.edge_sel;
        rise      = ~prev & cur;
        fall      = prev & ~cur;
        want      = (cfg.value & rise) | (~cfg.value & fall);
        edge_miss = cfg.mask & cfg.edge_sel & ~want;
        sel       = (cfg_level(cfg.cfg) == 8'(level));
        hit       = sel && (lvl_miss == '0) && (edge_miss == '0);
        start     = cfg_start(cfg.cfg);
    end
endmodule

// File: rtl/trig_seq.sv
module trig_seq
    import trg_pkg::*;
#(
    parameter int NST = N_STAGES,
    parameter int LW  = LVL_W,
    parameter int AW  = ADDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [CH_W-1:0]  cfg_data,
    input  logic             smp_valid,
    input  logic [CH_W-1:0]  smp_cur,
    input  logic [CH_W-1:0]  smp_prev,
    output logic             fire,
    output logic             fired,
    output logic [LW-1:0]    level
);
    localparam logic [LW-1:0] LVL_TOP = LW'(NST - 1);

    stage_cfg_t [NST-1:0] stages;
    logic [NST-1:0] st_sel, st_hit, st_start;
    logic any_hit, any_start;

    trg_stage_regs #(.NST(NST), .AW(AW)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_data), .stages(stages)
    );

    for (genvar s = 0; s < NST; s++) begin : g_match
        trg_stage_match #(.LW(LW)) u_match (
            .cfg(stages[s]), .cur(smp_cur), .prev(smp_prev), .level(level),
            .sel(st_sel[s]), .hit(st_hit[s]), .start(st_start[s])
        );
    end

    assign any_hit   = |st_hit;
    assign any_start = |(st_hit & st_start);

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            level <= '0;
            fired <= 1'b0;
            fire  <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (smp_valid && !fired) begin
                if (any_start) begin
                    fire  <= 1'b1;
                    fired <= 1'b1;
                end else if (any_hit && level != LVL_TOP) begin
                    level <= level + 1'b1;
                end
            end
        end
    end

    // R8
    fire_single_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);
    // R6
    fire_after_valid_chk: assert property (@(posedge clk) disable iff (rst)
        fire |-> $past(smp_valid));
    // R7
    level_step_chk: assert property (@(posedge clk) disable iff (rst)
        (level != $past(level)) |-> (level == '0 || level == $past(level) + 1'b1));
    // R9
    arm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        arm |=> (level == '0 && !fired && !fire));
    // R8
    fired_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (fired && !arm) |=> (fired && $stable(level)));
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && !arm) |=> ($stable(level) && !fire));
endmodule

// File: tb/trig_seq_bench.sv
module trig_seq_bench;
    logic clk = 1'b0;
    logic rst, arm, cfg_we, smp_valid;
    logic [3:0] cfg_addr;
    logic [31:0] cfg_data, smp_cur, smp_prev;
    logic fire, fired;
    logic [1:0] level;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    trig_seq u_trig_seq (
        .clk(clk), .rst(rst), .arm(arm), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .smp_valid(smp_valid), .smp_cur(smp_cur),
        .smp_prev(smp_prev), .fire(fire), .fired(fired), .level(level)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        arm = 0; cfg_we = 0; smp_valid = 0;
    endtask

    task automatic wr(input int stage, input int kind, input logic [31:0] d);
        @(negedge clk);
        idle_inputs();
        cfg_we = 1; cfg_addr = 4'((stage << 2) | kind); cfg_data = d;
        @(posedge clk); #1;
    endtask

    task automatic do_arm();
        @(negedge clk);
        idle_inputs();
        arm = 1;
        @(posedge clk); #1;
    endtask

    task automatic smp(input logic [31:0] c, input logic [31:0] p, input logic v);
        @(negedge clk);
        idle_inputs();
        smp_valid = v; smp_cur = c; smp_prev = p;
        @(posedge clk); #1;
    endtask

    task automatic park(input int stage);
        wr(stage, 0, 0); wr(stage, 1, 0); wr(stage, 3, 0);
        wr(stage, 2, 32'h0003_0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] base, bit_m, good, bad;
        rst = 1; idle_inputs(); cfg_addr = 0; cfg_data = 0; smp_cur = 0; smp_prev = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // R1 reset state
        chk("R1 fire", {31'b0, fire}, 0);
        chk("R1 fired", {31'b0, fired}, 0);
        chk("R1 level", {30'b0, level}, 0);
        smp(32'h0, 32'hFFFF_FFFF, 1);
        smp(32'hFFFF_FFFF, 32'h0, 1);
        chk("R1 parked stages never fire", {31'b0, fire | fired}, 0);
        chk("R1 level stays", {30'b0, level}, 0);

        // R11 immediate trigger with all-zero mask on stage 0
        wr(0, 2, 32'h0800_0000);
        do_arm();
        smp(32'h1234_5678, 32'h0, 1);
        chk("R11 zero mask fires at once", {31'b0, fire}, 1);
        chk("R6 fired set", {31'b0, fired}, 1);
        smp(32'h1234_5678, 32'h0, 1);
        chk("R8 fire single cycle", {31'b0, fire}, 0);

        base = 32'h5A3C_96E1;
        // R3 level sweep over every channel and polarity; R2 address of stage 0 words
        for (int c = 0; c < 32; c++) begin
            for (int v = 0; v < 2; v++) begin
                bit_m = 32'h1 << c;
                good = v ? (base | bit_m) : (base & ~bit_m);
                bad  = good ^ bit_m;
                wr(0, 0, bit_m);
                wr(0, 1, v ? bit_m : 32'h0);
                do_arm();
                chk("R9 arm clears fired", {31'b0, fired}, 0);
                smp(bad, ~bad, 1);
                chk("R3 mismatch no fire", {31'b0, fire}, 0);
                smp(good, good, 0);
                chk("R10 invalid sample ignored", {31'b0, fire | fired}, 0);
                smp(good, bad, 1);
                chk("R3 match fires", {31'b0, fire}, 1);
            end
        end

        // R4 edge sweep
        for (int c = 0; c < 32; c++) begin
            for (int v = 0; v < 2; v++) begin
                bit_m = 32'h1 << c;
                wr(0, 0, bit_m);
                wr(0, 3, bit_m);
                wr(0, 1, v ? bit_m : 32'h0);
                do_arm();
                good = v ? (base | bit_m) : (base & ~bit_m);
                bad  = good ^ bit_m;
                smp(good, good, 1);
                chk("R4 no transition no fire", {31'b0, fire}, 0);
                smp(bad, good, 1);
                chk("R4 wrong direction no fire", {31'b0, fire}, 0);
                smp(good, bad, 1);
                chk("R4 right edge fires", {31'b0, fire}, 1);
            end
        end

        // R5 R7 two-stage sequence
        wr(0, 3, 0);
        wr(0, 0, 32'hFF); wr(0, 1, 32'h12); wr(0, 2, 32'h0000_0000);
        wr(1, 0, 32'hFF); wr(1, 1, 32'h34); wr(1, 2, 32'h0801_0000);
        do_arm();
        smp(32'h34, 0, 1);
        chk("R5 later stage not evaluated", {31'b0, fire}, 0);
        chk("R5 level holds", {30'b0, level}, 0);
        smp(32'h12, 0, 1);
        chk("R7 advance to level 1", {30'b0, level}, 1);
        chk("R7 no fire on non-start", {31'b0, fire}, 0);
        smp(32'h12, 0, 1);
        chk("R5 stage 0 ignored at level 1", {30'b0, level}, 1);
        smp(32'h34, 0, 0);
        chk("R10 no fire without valid", {31'b0, fire}, 0);
        smp(32'h34, 0, 1);
        chk("R6 second stage fires", {31'b0, fire}, 1);
        smp(32'h34, 0, 1);
        chk("R8 no re-fire", {31'b0, fire}, 0);
        chk("R8 fired held", {31'b0, fired}, 1);
        do_arm();
        chk("R9 arm clears level", {30'b0, level}, 0);

        // R7 saturation: all stages zero mask, no start, levels 0..3
        for (int s = 0; s < 4; s++) begin
            wr(s, 0, 0); wr(s, 3, 0); wr(s, 2, 32'(s) << 16);
        end
        do_arm();
        for (int k = 1; k <= 5; k++) begin
            smp(32'hDEAD_BEEF, 0, 1);
            chk("R7 saturating level", {30'b0, level}, (k > 3) ? 3 : k);
            chk("R7 no fire", {31'b0, fire}, 0);
        end

        // R2 write to stage 2 only; stage 0 start must stay unaffected
        for (int s = 0; s < 4; s++) park(s);
        wr(2, 2, 32'h0800_0000);
        do_arm();
        smp(32'h0, 32'h0, 1);
        chk("R2 stage 2 config decoded", {31'b0, fire}, 1);
        park(2);
        do_arm();
        smp(32'h0, 32'h0, 1);
        chk("R2 parked again", {31'b0, fire}, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule